// File: doc/BRIEF.md
# Phase-Error Lock Qualifier for a Digital PLL

This block decides whether a digital PLL has settled onto its reference. It watches the signed phase-error word that the loop's phase detector produces. That word is the offset between the incoming reference and the fed-back output clock. Each valid sample is reduced to its magnitude and compared against a programmable limit. Time is divided into fixed monitoring windows. The default window is 4 ms of a 50 MHz system clock, and the length is a parameter.

A window counts as good when no valid sample in it reached the limit. The lock flag rises once the number of back-to-back good windows reaches a programmable target. The flag drops two clock edges after any offending sample is presented, and the run of good windows then starts again from zero. Each change of the flag produces a one-cycle event pulse. Software-facing logic can use that pulse to set a sticky status bit.

Top module: `pll_lock_detector`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `locked` and `lock_chg` are 0.
- R2: A sample with `ph_valid` high is "excessive" when the absolute value of `ph_err`, read as two's complement, is greater than or equal to `thr` (unsigned). This holds for both signs, so a `thr` of 0 makes every valid sample excessive.
- R3: A sample whose magnitude equals `thr` exactly is excessive. A sample whose magnitude is one below `thr` is not.
- R4: The windows are `WIN_CYCLES` clocks long. `locked` rises only on the cycle after a window closes, and only once the count of consecutive good windows has reached `win_need`.
- R5: `locked` drops on the second rising edge after an excessive sample is presented. The good-window count returns to zero, and the window holding that sample is not counted as good.
- R6: A `win_need` of 0 behaves as 1.
- R7: `lock_chg` is high for exactly the one cycle in which `locked` shows a new value, and it is low on every other cycle.
- R8: When `ph_valid` is low, the value on `ph_err` has no effect on the lock state.
- R9: The good-window count saturates at its maximum. `locked` stays high for as long as no excessive sample arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ph_valid | input | 1 | Phase-error sample strobe |
| ph_err | input | PHASE_W | Signed phase-error sample |
| thr | input | PHASE_W | Unsigned magnitude limit |
| win_need | input | CNT_W | Consecutive good windows needed for lock |
| locked | output | 1 | Lock flag (registered) |
| lock_chg | output | 1 | One-cycle pulse on every change of `locked` |

## Verification
The embedded properties check on every cycle that the flag rises only right after a window boundary. They also check that it falls one edge after an excessive sample has been registered, that the change pulse matches each flag transition exactly, and that a strobe-low sample never registers as excessive. Other behaviours can only be shown by the bench's scenarios against its behavioural model. These are how many windows must pass before lock, the exact handling of the threshold boundary for negative and positive samples, the treatment of a zero target, saturation over long good runs, and the restart of counting after a loss.

// File: rtl/lock_det_pkg.sv
package lock_det_pkg;

  // 4 ms at a 50 MHz system clock
  localparam int unsigned DEF_WIN_CYCLES = 200_000;

  // Counter width able to hold 0 .. n-1, never narrower than one bit
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // Events handed from the front-end stages to the lock qualifier
  typedef struct packed {
    logic tick;  // a monitoring window closes this cycle
    logic bad;   // an excessive phase sample was registered this cycle
  } mon_evt_t;

endpackage

// File: rtl/lock_win_timer.sv
module lock_win_timer #(
  parameter int unsigned WIN_CYCLES = lock_det_pkg::DEF_WIN_CYCLES
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned CW   = lock_det_pkg::cnt_width(WIN_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(WIN_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      tick  <= wrap;
    end
  end

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

  generate
    if (WIN_CYCLES > 1) begin : g_gap
      // R4
      tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/phase_excess_cmp.sv
module phase_excess_cmp #(
  parameter int unsigned PHASE_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ph_valid,
  input  logic [PHASE_W-1:0] ph_err,
  input  logic [PHASE_W-1:0] thr,
  output logic               bad
);
  logic [PHASE_W-1:0] mag;
  logic               over;

  // Two's-complement magnitude; the most negative code maps to 2^(PHASE_W-1)
  always_comb begin
    if (ph_err[PHASE_W-1]) mag = ~ph_err + 1'b1;
    else                   mag = ph_err;
    over = (mag >= thr);
  end

  always_ff @(posedge clk) begin
    if (rst) bad <= 1'b0;
    else     bad <= ph_valid & over;
  end

  // R8
  idle_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !ph_valid |=> !bad);

  // R2
  zero_thr_chk: assert property (@(posedge clk) disable iff (rst)
    (ph_valid && thr == '0) |=> bad);

endmodule

// File: rtl/lock_qualifier.sv
module lock_qualifier #(
  parameter int unsigned CNT_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  lock_det_pkg::mon_evt_t  evt,
  input  logic [CNT_W-1:0]        win_need,
  output logic                    locked,
  output logic                    lock_chg
);
  logic [CNT_W-1:0] good_q, good_d, good_inc, need_eff;
  logic             wbad_q, wbad_d;
  logic             lock_d;

  assign need_eff = (win_need == '0) ? CNT_W'(1) : win_need;
  assign good_inc = (good_q == '1) ? good_q : good_q + 1'b1;

  always_comb begin
    good_d = good_q;
    wbad_d = wbad_q;
    lock_d = locked;
    if (evt.bad) begin
      // loss is immediate; a sample landing on a boundary fails the closing window
      lock_d = 1'b0;
      good_d = '0;
      wbad_d = !evt.tick;
    end else if (evt.tick) begin
      wbad_d = 1'b0;
      if (wbad_q) begin
        good_d = '0;
      end else begin
        good_d = good_inc;
        if (good_inc >= need_eff) lock_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      good_q   <= '0;
      wbad_q   <= 1'b0;
      locked   <= 1'b0;
      lock_chg <= 1'b0;
    end else begin
      good_q   <= good_d;
      wbad_q   <= wbad_d;
      locked   <= lock_d;
      lock_chg <= lock_d ^ locked;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!locked && !lock_chg));

  // R5
  loss_chk: assert property (@(posedge clk) disable iff (rst)
    evt.bad |=> !locked);

  // R4
  rise_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(evt.tick));

  // R7
  chg_cover_chk: assert property (@(posedge clk) disable iff (rst)
    (locked != $past(locked)) |-> lock_chg);

  // R7
  chg_only_chk: assert property (@(posedge clk) disable iff (rst)
    lock_chg |-> (locked != $past(locked)));

endmodule

// File: rtl/pll_lock_detector.sv
module pll_lock_detector #(
  parameter int unsigned PHASE_W    = 16,
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned WIN_CYCLES = lock_det_pkg::DEF_WIN_CYCLES
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ph_valid,
  input  logic [PHASE_W-1:0] ph_err,
  input  logic [PHASE_W-1:0] thr,
  input  logic [CNT_W-1:0]   win_need,
  output logic               locked,
  output logic               lock_chg
);
  lock_det_pkg::mon_evt_t evt;

  lock_win_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .tick (evt.tick)
  );

  phase_excess_cmp #(.PHASE_W(PHASE_W)) u_cmp (
    .clk      (clk),
    .rst      (rst),
    .ph_valid (ph_valid),
    .ph_err   (ph_err),
    .thr      (thr),
    .bad      (evt.bad)
  );

  lock_qualifier #(.CNT_W(CNT_W)) u_qual (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt),
    .win_need (win_need),
    .locked   (locked),
    .lock_chg (lock_chg)
  );

endmodule

// File: tb/tb_pll_lock_detector.sv
module tb_pll_lock_detector;
  localparam int PW  = 12;
  localparam int CW  = 4;
  localparam int WIN = 25;

  logic clk = 1'b0, rst = 1'b1, ph_valid = 1'b0;
  logic [PW-1:0] ph_err = '0, thr = '0;
  logic [CW-1:0] win_need = '0;
  logic locked, lock_chg;

  always #10 clk = ~clk;

  pll_lock_detector #(.PHASE_W(PW), .CNT_W(CW), .WIN_CYCLES(WIN)) dut (
    .clk(clk), .rst(rst), .ph_valid(ph_valid), .ph_err(ph_err), .thr(thr),
    .win_need(win_need), .locked(locked), .lock_chg(lock_chg));

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Behavioural reference model, advanced on each rising edge
  int m_pos = 0, m_tick = 0, m_bad = 0, m_wbad = 0, m_good = 0, m_lk = 0, m_chg = 0;
  always @(posedge clk) begin
    int v, mag, need, nlk, ng, nwb;
    if (rst) begin
      m_pos = 0; m_tick = 0; m_bad = 0; m_wbad = 0; m_good = 0; m_lk = 0; m_chg = 0;
    end else begin
      nlk = m_lk; ng = m_good; nwb = m_wbad;
      need = (int'(win_need) == 0) ? 1 : int'(win_need);
      if (m_bad != 0) begin
        nlk = 0; ng = 0; nwb = (m_tick != 0) ? 0 : 1;
      end else if (m_tick != 0) begin
        if (m_wbad != 0) ng = 0;
        else begin
          if (ng < (1 << CW) - 1) ng = ng + 1;
          if (ng >= need) nlk = 1;
        end
        nwb = 0;
      end
      m_chg = (nlk != m_lk) ? 1 : 0;
      m_lk = nlk; m_good = ng; m_wbad = nwb;
      v = int'($signed(ph_err));
      mag = (v < 0) ? -v : v;
      m_bad = (ph_valid && mag >= int'(thr)) ? 1 : 0;
      m_tick = (m_pos == WIN - 1) ? 1 : 0;
      m_pos = (m_pos == WIN - 1) ? 0 : m_pos + 1;
    end
  end

  int trans = 0, pulses = 0;
  logic prev_lk = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      chk(int'(locked) == m_lk, "R4/R5 model lock", int'(locked), m_lk);
      chk(int'(lock_chg) == m_chg, "R7 model change", int'(lock_chg), m_chg);
      if (locked != prev_lk) trans++;
      if (lock_chg) pulses++;
      prev_lk = locked;
    end
  end

  task automatic cyc(input bit v, input int val);
    @(negedge clk);
    ph_valid = v;
    ph_err   = PW'(val);
  endtask

  task automatic run(input int n, input int amp);
    for (int i = 0; i < n; i++)
      cyc(1'b1, int'($urandom_range(0, 2 * amp)) - amp);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #4_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    thr = PW'(100); win_need = CW'(3);
    repeat (3) @(negedge clk);
    // R1
    chk(!locked && !lock_chg, "R1 reset state", int'({locked, lock_chg}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!locked && !lock_chg, "R1 after release", int'({locked, lock_chg}), 0);

    // R4: three good windows needed
    run(60, 60);
    chk(locked == 1'b0, "R4 not yet locked", int'(locked), 0);
    run(40, 60);
    chk(locked == 1'b1, "R4 locked after target", int'(locked), 1);

    // R3: magnitude one below limit is harmless
    cyc(1'b1, 99); run(3, 60);
    chk(locked == 1'b1, "R3 below limit", int'(locked), 1);
    cyc(1'b1, -99); run(3, 60);
    chk(locked == 1'b1, "R2 negative below limit", int'(locked), 1);

    // R8: strobe low ignores a huge value
    cyc(1'b0, -2047); cyc(1'b0, 2047); run(3, 60);
    chk(locked == 1'b1, "R8 strobe low ignored", int'(locked), 1);

    // R3/R5: negative sample exactly at the limit drops lock two edges later
    cyc(1'b1, -100); run(2, 60);
    chk(locked == 1'b0, "R3 equal magnitude drops lock", int'(locked), 0);

    // R5: count restarted, needs three more full windows
    run(45, 60);
    chk(locked == 1'b0, "R5 count restarted", int'(locked), 0);
    run(60, 60);
    chk(locked == 1'b1, "R5 relocked", int'(locked), 1);

    // R2: positive excess
    cyc(1'b1, 2047); run(2, 60);
    chk(locked == 1'b0, "R2 positive excess", int'(locked), 0);

    // R6: zero target behaves as one window
    win_need = '0;
    run(60, 60);
    chk(locked == 1'b1, "R6 zero target", int'(locked), 1);

    // R2: zero threshold makes every valid sample excessive
    thr = '0;
    run(2, 0);
    chk(locked == 1'b0, "R2 zero threshold", int'(locked), 0);
    run(100, 60);
    chk(locked == 1'b0, "R2 zero threshold held", int'(locked), 0);
    thr = PW'(100);

    // R9: largest target, count saturates and lock holds
    win_need = CW'(15);
    run(15 * WIN + 50, 60);
    chk(locked == 1'b1, "R9 locked at max target", int'(locked), 1);
    run(250, 60);
    chk(locked == 1'b1, "R9 lock held after saturation", int'(locked), 1);

    // R7: one pulse per observed transition
    chk(trans == pulses, "R7 pulse count", pulses, trans);

    summary();
    $finish;
  end

endmodule